// File: doc/BRIEF.md
# Mixed-Cell Approximate Array Multiplier

This block multiplies two unsigned operands of `W` bits (4 by default) with a row-ripple array of full-adder cells. Every cell position in the array is bound at elaboration time to one of four cell kinds: an exact full adder or one of three deliberately inexact ones. A single configuration parameter carries one 2-bit code per position. A uniform array (all cells the same kind) and a mixed array come from the same source, so the configurations can be compared in accuracy and cost.

The partial product bits are `opa[c] & opb[r]`. Row 0 of the partial products is not added. Its least significant bit is product bit 0, and its upper bits form the first running sum. Each of the `W-1` adder rows adds the next partial-product row to the running sum with a ripple carry. The lowest sum bit of each row retires as one product bit. The rest of the sum, topped by the row carry-out, passes down to the next row. The product is captured in an output register with a synchronous active-high reset. The search for a good configuration is done elsewhere, offline.

Top module: `mixcell_mul`

## Requirements
- R1: When `rst` is high at a rising clock edge, `prod` is 0 after that edge, whatever the operands and the configuration.
- R2: `prod` changes only at a rising edge. It then shows the result for the operands sampled at that edge, so the latency is one cycle.
- R3: With every configuration code 0 (exact), `prod` equals `opa*opb` for all operand pairs.
- R4: In every configuration, product bit 0 equals `opa[0] & opb[0]`.
- R5: The code for adder row k (0 to W-2, the row that adds `opa & opb[k+1]`) and column c (0 to W-1) sits at bits [2*(k*W+c) +: 2] of `CFG`. The codes are 0 exact, 1 kind A, 2 kind B, 3 kind C. At a cell, input x is `opa[c] & opb[k+1]`, input y is running-sum bit c, and input z is the carry from column c-1 (0 for column 0).
- R6: A kind-A cell drives carry = majority(x,y,z) and sum = NOT carry.
- R7: A kind-B cell drives sum = x XOR y XOR z and carry = x.
- R8: A kind-C cell drives carry = majority(x,y,z) and sum = z AND NOT(x AND y). This equals z except that x=y=z=1 gives 0.
- R9: The positions in a mixed configuration act independently. For every operand pair, `prod` equals a cell-by-cell model using each position's own code.
- R10: Row k retires its sum bit 0 as product bit k+1. The carry-out of the last row is product bit 2W-1, and no carry is dropped, so 15*15 gives 225 in the exact configuration.
- R11: While the operands are held, `prod` stays unchanged from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opa | input | W | Multiplicand |
| opb | input | W | Multiplier; bit r selects partial-product row r |
| prod | output | 2*W | Registered product |

## Verification
The hardest case to reach is one where a single position's code decides the result. The operands must put a specific x, y, z triple on an inner cell, and that cell's inputs depend on every cell above and to the right of it. The stimulus does not aim at individual cells. It sweeps all 256 operand pairs through five instances side by side (exact, three uniform arrays and one mixed array that uses all four codes), so every reachable triple at every position occurs. The all-zero operands give a hand-known value for the uniform kind-A array, because its sum is 1 even when all three inputs are 0.

// File: rtl/mixcell_pkg.sv
package mixcell_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CELL_EXACT  = 2'd0,
    CELL_KIND_A = 2'd1,
    CELL_KIND_B = 2'd2,
    CELL_KIND_C = 2'd3
  } cell_kind_e;
endpackage

// File: rtl/mixcell_fa.sv
module mixcell_fa
  import mixcell_pkg::*;
#(
  parameter logic [CODE_W-1:0] KIND = CELL_EXACT
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  logic maj, par;

  assign maj = (x & y) | (z & (x ^ y));
  assign par = x ^ y ^ z;

  always_comb begin
    case (cell_kind_e'(KIND))
      CELL_KIND_A: begin
        co = maj;
        s  = ~maj;
      end
      CELL_KIND_B: begin
        co = x;
        s  = par;
      end
      CELL_KIND_C: begin
        co = maj;
        s  = z & ~(x & y);
      end
      default: begin
        co = maj;
        s  = par;
      end
    endcase
  end
endmodule

// File: rtl/mixcell_row.sv
module mixcell_row
  import mixcell_pkg::*;
#(
  parameter int W = 4,
  parameter logic [CODE_W*W-1:0] KINDS = '0
) (
  input  logic [W-1:0] pp,
  input  logic [W-1:0] acc,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar c = 0; c < W; c++) begin : g_col
    mixcell_fa #(.KIND(KINDS[CODE_W*c +: CODE_W])) cell_i (
      .x (pp[c]),
      .y (acc[c]),
      .z (carry[c]),
      .s (sum[c]),
      .co(carry[c+1])
    );
  end

  assign cout = carry[W];
endmodule

// File: rtl/mixcell_mul.sv
module mixcell_mul
  import mixcell_pkg::*;
#(
  parameter int W = 4,
  parameter logic [CODE_W*W*(W-1)-1:0] CFG = 24'h6C_93_B1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] prod
);
  localparam int ROWS  = W - 1;
  localparam int ROW_W = CODE_W * W;
  localparam int PW    = 2 * W;

  logic [W-1:0]  pp   [W];
  logic [W-1:0]  acc  [W];
  logic [PW-1:0] prod_c;

  for (genvar r = 0; r < W; r++) begin : g_pp
    assign pp[r] = opa & {W{opb[r]}};
  end

  assign prod_c[0] = pp[0][0];
  assign acc[0]    = {1'b0, pp[0][W-1:1]};

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    logic [W-1:0] sum;
    logic         cout;

    mixcell_row #(
      .W    (W),
      .KINDS(CFG[ROW_W*k +: ROW_W])
    ) row_i (
      .pp  (pp[k+1]),
      .acc (acc[k]),
      .sum (sum),
      .cout(cout)
    );

    assign prod_c[k+1] = sum[0];
    assign acc[k+1]    = {cout, sum[W-1:1]};
  end

  assign prod_c[PW-1:W] = acc[ROWS];

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_c;
  end
endmodule

// File: rtl/mixcell_mul_chk.sv
module mixcell_mul_chk
  import mixcell_pkg::*;
#(
  parameter int W = 4,
  parameter logic [CODE_W*W*(W-1)-1:0] CFG = '0
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic [2*W-1:0] prod
);
  localparam bit ALL_EXACT = (CFG == '0);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> prod == '0);

  assert_low_bit_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod[0] == ($past(opa[0]) & $past(opb[0])));

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(opa) && $stable(opb)) |=> $stable(prod));

  if (ALL_EXACT) begin : g_exact
    assert_exact_product_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> prod == ({{W{1'b0}}, $past(opa)} * {{W{1'b0}}, $past(opb)}));
  end
endmodule

bind mixcell_mul mixcell_mul_chk #(.W(W), .CFG(CFG)) chk_i (
  .clk (clk),
  .rst (rst),
  .opa (opa),
  .opb (opb),
  .prod(prod)
);

// File: tb/mixcell_mul_tb.sv
`timescale 1ns/1ps
module mixcell_mul_tb_top;
  localparam logic [23:0] MIX  = 24'h1B_E4_72;
  localparam logic [23:0] UNIA = 24'h55_55_55;
  localparam logic [23:0] UNIB = 24'hAA_AA_AA;
  localparam logic [23:0] UNIC = 24'hFF_FF_FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] opa = 4'd5, opb = 4'd9;
  logic [7:0] p_mix, p_ex, p_a, p_b, p_c;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mixcell_mul #(.W(4), .CFG(MIX))   dut_i  (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .prod(p_mix));
  mixcell_mul #(.W(4), .CFG(24'h0)) dut_ex (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .prod(p_ex));
  mixcell_mul #(.W(4), .CFG(UNIA))  dut_a  (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .prod(p_a));
  mixcell_mul #(.W(4), .CFG(UNIB))  dut_b  (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .prod(p_b));
  mixcell_mul #(.W(4), .CFG(UNIC))  dut_c  (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .prod(p_c));

  // cell behaviour from R6..R8; returns {carry, sum}
  function automatic logic [1:0] cell_model(int kind, bit x, bit y, bit z);
    bit m;
    m = (x && y) || (z && (x != y));
    case (kind)
      1: return {m, !m};
      2: return {x, x ^ y ^ z};
      3: return {m, z && !(x && y)};
      default: return {m, x ^ y ^ z};
    endcase
  endfunction

  // behavioural product model following R5 and R10
  function automatic logic [7:0] mul_model(logic [23:0] cfg, logic [3:0] a, logic [3:0] b);
    logic [7:0] p;
    logic [3:0] run;
    p = '0;
    p[0] = a[0] & b[0];
    run = {1'b0, a[3:1] & {3{b[0]}}};
    for (int k = 0; k < 3; k++) begin
      logic [3:0] s;
      bit cy;
      cy = 1'b0;
      for (int c = 0; c < 4; c++) begin
        logic [1:0] r;
        r = cell_model(int'(cfg[2*(k*4+c) +: 2]), a[c] & b[k+1], run[c], cy);
        s[c] = r[0];
        cy = r[1];
      end
      p[k+1] = s[0];
      run = {cy, s[3:1]};
    end
    p[7:4] = run;
    return p;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (a=%0d b=%0d)", tag, act, exp, opa, opb);
    end
  endtask

  task automatic apply(logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    opa = a;
    opb = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset mix", p_mix, 8'h00);
    check("R1 reset exact", p_ex, 8'h00);
    check("R1 reset kindA", p_a, 8'h00);
    check("R1 reset kindB", p_b, 8'h00);
    check("R1 reset kindC", p_c, 8'h00);

    // R2: one-cycle latency
    @(negedge clk);
    rst = 1'b0;
    #1 check("R2 before edge", p_ex, 8'h00);
    @(negedge clk);
    check("R2 after edge", p_ex, 8'd45);

    // hand-known values
    apply(4'd0, 4'd0);
    check("R6 kindA zeros", p_a, 8'h7E);
    check("R7 kindB zeros", p_b, 8'h00);
    check("R8 kindC zeros", p_c, 8'h00);
    apply(4'd15, 4'd15);
    check("R10 max product", p_ex, 8'hE1);
    check("R10 top bit", {7'd0, p_ex[7]}, 8'd1);

    // full sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(4'(a), 4'(b));
        check("R3 exact", p_ex, 8'(a * b));
        check("R9 R5 mixed", p_mix, mul_model(MIX, 4'(a), 4'(b)));
        check("R6 kindA", p_a, mul_model(UNIA, 4'(a), 4'(b)));
        check("R7 kindB", p_b, mul_model(UNIB, 4'(a), 4'(b)));
        check("R8 kindC", p_c, mul_model(UNIC, 4'(a), 4'(b)));
        check("R4 bit0", {7'd0, p_mix[0]}, {7'd0, 1'(a & b & 1)});
      end
    end

    // R11: held operands keep the product
    apply(4'd11, 4'd6);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 hold mix", p_mix, mul_model(MIX, 4'd11, 4'd6));
      check("R11 hold exact", p_ex, 8'd66);
    end

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset mix", p_mix, 8'h00);
    check("R1 mid reset kindA", p_a, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", p_ex, 8'd66);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule